// File: doc/BRIEF.md
# Restart-Vectored Interrupt Acceptance Unit

This block holds the interrupt side of a small 8-bit processor core. A single enable flag gates the whole interrupt system. Enable and disable commands that retire with an instruction set and clear the flag. A pending request is looked at only at an instruction boundary, which is the cycle in which the core reports that an instruction has fully completed. When the request is accepted, the enable flag drops. The core is then held for two cycles, and the next instruction is taken from the interrupting device over the data bus instead of from memory.

A device-side responder is built in. It drives a one-byte restart opcode, `11nnn111`, for its configured restart number `nnn`. It drives the byte only in the single cycle in which the acknowledge output is high. The unit then runs that restart as a call. The return address it presents is the program counter, which the fetch from the device did not advance. The program counter is then loaded with the slot address `nnn × 8`. That gives eight entry points, each eight bytes long, in the lowest 64 bytes of the address space.

The enable command takes effect one instruction late. A return placed directly after the enable command therefore completes before a new request can be taken.

Top module: `irq_restart_unit`

## Requirements
- R1: After reset, `inte` is 0, `pc` is 0x0000, and `inta`, `push_valid` and `core_hold` are 0.
- R2: At each instruction boundary (`instr_done` high while `core_hold` is low), `pc` advances by `instr_len`. This includes the boundary at which a request is accepted.
- R3: When `cmd_ei` retires at boundary k, a request at boundary k is not accepted and `inte` stays 0. At boundary k+1, `inte` becomes 1 and a request present there is accepted.
- R4: When `cmd_di` retires at a boundary, `inte` is 0 after that boundary, and a request present at that same boundary is not accepted.
- R5: While the enable is off, `irq_req` has no effect: `inta` stays 0 and `pc` advances by `instr_len` as usual.
- R6: A request accepted at a boundary causes the following:
  - `inta` is high for exactly the one cycle after that boundary.
  - `core_hold` is high for that cycle and the next.
  - `inte` reads 0 from the acknowledge cycle on.
- R7: While `inta` is high, `data_bus` carries `{2'b11, n, 3'b111}`, where n is the configured restart number. At every other time, `data_bus` is 0x00.
- R8: In the cycle after `inta`, `push_valid` is high for one cycle and `push_addr` equals the program counter left by the interrupted instruction. Fetching the device byte does not change `pc`.
- R9: In the cycle after `push_valid`, `pc` equals n × 8, and `core_hold` is low.
- R10: `instr_done`, `cmd_ei` and `cmd_di` are ignored while `core_hold` is high. They move neither `pc` nor the enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_done | input | 1 | The current instruction completes in this cycle |
| instr_len | input | 2 | Byte length of the completing instruction |
| cmd_ei | input | 1 | The completing instruction is an enable command |
| cmd_di | input | 1 | The completing instruction is a disable command |
| irq_req | input | 1 | Interrupt request from the device |
| dev_vec | input | 3 | Restart number the responder supplies |
| inta | output | 1 | Interrupt acknowledge; the device drives the bus |
| data_bus | output | 8 | Instruction byte driven by the responder |
| inte | output | 1 | Interrupt enable flag |
| core_hold | output | 1 | The core must stall; the unit owns the fetch |
| pc | output | 16 | Program counter |
| push_valid | output | 1 | The restart call pushes a return address |
| push_addr | output | 16 | Return address to push |

## Verification
A stale enable flag shows at the first boundary that carries a request. There, `inta` either rises when it should stay low or stays low when it should rise. An off-by-one in the enable delay shifts that decision by exactly one instruction. A wrong sequencer state shows within two cycles of acceptance as a wrong acknowledge width, a missing push, or a `pc` that moved during the device fetch. A bad restart decode shows one cycle later as a `pc` outside the expected slot base.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;

   localparam int OPC_W = 8;
   localparam int VEC_W = 3;

   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_ACK  = 2'd1,
      SEQ_CALL = 2'd2
   } seq_state_t;

   function automatic logic [OPC_W-1:0] rst_opcode(input logic [VEC_W-1:0] n);
      return {2'b11, n, 3'b111};
   endfunction

   function automatic logic is_rst(input logic [OPC_W-1:0] b);
      return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
   endfunction

   function automatic logic [VEC_W-1:0] rst_num(input logic [OPC_W-1:0] b);
      return b[5:3];
   endfunction

endpackage

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl #(
   parameter bit EI_DELAY = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic boundary,
   input  logic cmd_ei,
   input  logic cmd_di,
   input  logic accept,
   output logic inte,
   output logic en_eff
);

   logic inte_q;
   logic arm_q;

   generate
      if (EI_DELAY) begin : g_delayed
         // an enable retiring now arms; the flag rises one boundary later
         always_ff @(posedge clk) begin
            if (rst) begin
               inte_q <= 1'b0;
               arm_q  <= 1'b0;
            end else if (accept) begin
               inte_q <= 1'b0;
               arm_q  <= 1'b0;
            end else if (boundary) begin
               if (cmd_di) begin
                  inte_q <= 1'b0;
                  arm_q  <= 1'b0;
               end else begin
                  inte_q <= inte_q | arm_q;
                  arm_q  <= cmd_ei;
               end
            end
         end
         assign en_eff = (inte_q | arm_q) & ~cmd_di;

         a_r3_ei_late : assert property (@(posedge clk) disable iff (rst)
            (boundary && cmd_ei && !cmd_di && !inte_q && !arm_q) |=> !inte_q);
      end else begin : g_immediate
         always_ff @(posedge clk) begin
            if (rst) begin
               inte_q <= 1'b0;
            end else if (accept) begin
               inte_q <= 1'b0;
            end else if (boundary) begin
               if (cmd_di)      inte_q <= 1'b0;
               else if (cmd_ei) inte_q <= 1'b1;
            end
         end
         assign arm_q  = 1'b0;
         assign en_eff = inte_q & ~cmd_di;
      end
   endgenerate

   assign inte = inte_q;

   a_r4_di_clears : assert property (@(posedge clk) disable iff (rst)
      (boundary && cmd_di) |=> !inte_q);

   a_r6_accept_clears : assert property (@(posedge clk) disable iff (rst)
      accept |=> !inte_q);

   a_r10_hold_keeps : assert property (@(posedge clk) disable iff (rst)
      (!boundary && !accept) |=> ($stable(inte_q) && $stable(arm_q)));

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
   import irq_rst_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             instr_done,
   input  logic             irq_req,
   input  logic             en_eff,
   input  logic [OPC_W-1:0] dev_byte,
   output logic             boundary,
   output logic             accept,
   output logic             inta,
   output logic             hold,
   output logic             call_fire,
   output logic [VEC_W-1:0] call_vec
);

   seq_state_t       state_q;
   seq_state_t       state_d;
   logic [OPC_W-1:0] opc_q;

   assign boundary = instr_done && (state_q == SEQ_RUN);
   assign accept   = boundary && irq_req && en_eff;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_RUN:  if (accept) state_d = SEQ_ACK;
         SEQ_ACK:  state_d = SEQ_CALL;
         SEQ_CALL: state_d = SEQ_RUN;
         default:  state_d = SEQ_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_RUN;
         opc_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == SEQ_ACK) opc_q <= dev_byte;
      end
   end

   assign inta      = (state_q == SEQ_ACK);
   assign hold      = (state_q != SEQ_RUN);
   assign call_fire = (state_q == SEQ_CALL) && is_rst(opc_q);
   assign call_vec  = rst_num(opc_q);

   a_r6_inta_single : assert property (@(posedge clk) disable iff (rst)
      inta |=> !inta);

   a_r6_inta_after_accept : assert property (@(posedge clk) disable iff (rst)
      accept |=> inta);

   a_r8_call_follows : assert property (@(posedge clk) disable iff (rst)
      inta |=> call_fire);

   a_r9_hold_ends : assert property (@(posedge clk) disable iff (rst)
      call_fire |=> !hold);

endmodule

// File: rtl/irq_dev_responder.sv
module irq_dev_responder
   import irq_rst_pkg::*;
#(
   parameter bit             VEC_FIXED = 1'b0,
   parameter int unsigned    FIXED_VEC = 0
) (
   input  logic             inta,
   input  logic [VEC_W-1:0] dev_vec,
   output logic [OPC_W-1:0] data_bus
);

   logic [VEC_W-1:0] vec_sel;

   generate
      if (VEC_FIXED) begin : g_fixed
         assign vec_sel = VEC_W'(FIXED_VEC);
      end else begin : g_port
         assign vec_sel = dev_vec;
      end
   endgenerate

   assign data_bus = inta ? rst_opcode(vec_sel) : '0;

endmodule

// File: rtl/irq_pc_unit.sv
module irq_pc_unit #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned LEN_W      = 2,
   parameter int unsigned VEC_W      = 3,
   parameter int unsigned SLOT_SHIFT = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              boundary,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic              call_fire,
   input  logic [VEC_W-1:0]  call_vec,
   output logic [ADDR_W-1:0] pc
);

   localparam int unsigned BASE_BITS = SLOT_SHIFT + VEC_W;

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] target;

   assign target = ADDR_W'(call_vec) << SLOT_SHIFT;

   always_ff @(posedge clk) begin
      if (rst)            pc_q <= '0;
      else if (call_fire) pc_q <= target;
      else if (boundary)  pc_q <= pc_q + ADDR_W'(instr_len);
   end

   assign pc = pc_q;

   a_r9_slot_base : assert property (@(posedge clk) disable iff (rst)
      call_fire |=> ((pc_q[SLOT_SHIFT-1:0] == '0) && ((pc_q >> BASE_BITS) == '0)));

   a_r8_pc_frozen : assert property (@(posedge clk) disable iff (rst)
      (!boundary && !call_fire) |=> $stable(pc_q));

endmodule

// File: rtl/irq_restart_unit.sv
module irq_restart_unit
   import irq_rst_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned LEN_W      = 2,
   parameter int unsigned SLOT_BYTES = 8,
   parameter bit          EI_DELAY   = 1'b1,
   parameter bit          VEC_FIXED  = 1'b0,
   parameter int unsigned FIXED_VEC  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              instr_done,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic              cmd_ei,
   input  logic              cmd_di,
   input  logic              irq_req,
   input  logic [2:0]        dev_vec,
   output logic              inta,
   output logic [7:0]        data_bus,
   output logic              inte,
   output logic              core_hold,
   output logic [ADDR_W-1:0] pc,
   output logic              push_valid,
   output logic [ADDR_W-1:0] push_addr
);

   localparam int unsigned SLOT_SHIFT = $clog2(SLOT_BYTES);

   generate
      if ((1 << SLOT_SHIFT) != SLOT_BYTES) begin : g_bad_slot
         $error("SLOT_BYTES must be a power of two");
      end
      if (ADDR_W < SLOT_SHIFT + VEC_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the restart area");
      end
      if (FIXED_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("FIXED_VEC out of range");
      end
      if (SLOT_SHIFT < 1) begin : g_bad_shift
         $error("SLOT_BYTES must be at least 2");
      end
   endgenerate

   logic             boundary;
   logic             accept;
   logic             en_eff;
   logic             call_fire;
   logic [VEC_W-1:0] call_vec;

   irq_enable_ctl #(
      .EI_DELAY (EI_DELAY)
   ) u_enable (
      .clk      (clk),
      .rst      (rst),
      .boundary (boundary),
      .cmd_ei   (cmd_ei),
      .cmd_di   (cmd_di),
      .accept   (accept),
      .inte     (inte),
      .en_eff   (en_eff)
   );

   irq_accept_seq u_seq (
      .clk        (clk),
      .rst        (rst),
      .instr_done (instr_done),
      .irq_req    (irq_req),
      .en_eff     (en_eff),
      .dev_byte   (data_bus),
      .boundary   (boundary),
      .accept     (accept),
      .inta       (inta),
      .hold       (core_hold),
      .call_fire  (call_fire),
      .call_vec   (call_vec)
   );

   irq_dev_responder #(
      .VEC_FIXED (VEC_FIXED),
      .FIXED_VEC (FIXED_VEC)
   ) u_resp (
      .inta     (inta),
      .dev_vec  (dev_vec),
      .data_bus (data_bus)
   );

   irq_pc_unit #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .VEC_W      (VEC_W),
      .SLOT_SHIFT (SLOT_SHIFT)
   ) u_pc (
      .clk       (clk),
      .rst       (rst),
      .boundary  (boundary),
      .instr_len (instr_len),
      .call_fire (call_fire),
      .call_vec  (call_vec),
      .pc        (pc)
   );

   assign push_valid = call_fire;
   assign push_addr  = pc;

   a_r7_bus_quiet : assert property (@(posedge clk) disable iff (rst)
      !inta |-> (data_bus == 8'h00));

   a_r7_bus_restart : assert property (@(posedge clk) disable iff (rst)
      inta |-> ((data_bus[7:6] == 2'b11) && (data_bus[2:0] == 3'b111)));

   a_r6_inte_low_in_ack : assert property (@(posedge clk) disable iff (rst)
      inta |-> !inte);

   a_r8_push_pc_held : assert property (@(posedge clk) disable iff (rst)
      inta |=> (push_addr == $past(pc)));

endmodule

// File: tb/irq_restart_unit_bench.sv
module irq_restart_unit_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        instr_done;
   logic [1:0]  instr_len;
   logic        cmd_ei;
   logic        cmd_di;
   logic        irq_req;
   logic [2:0]  dev_vec;
   logic        inta;
   logic [7:0]  data_bus;
   logic        inte;
   logic        core_hold;
   logic [15:0] pc;
   logic        push_valid;
   logic [15:0] push_addr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   irq_restart_unit u_irq_restart_unit (
      .clk(clk), .rst(rst), .instr_done(instr_done), .instr_len(instr_len),
      .cmd_ei(cmd_ei), .cmd_di(cmd_di), .irq_req(irq_req), .dev_vec(dev_vec),
      .inta(inta), .data_bus(data_bus), .inte(inte), .core_hold(core_hold),
      .pc(pc), .push_valid(push_valid), .push_addr(push_addr)
   );

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      instr_done = 1'b0; instr_len = 2'd0; cmd_ei = 1'b0;
      cmd_di = 1'b0; irq_req = 1'b0;
   endtask

   // one instruction boundary with optional commands and request
   task automatic retire(input logic [1:0] len, input logic ei,
                         input logic di, input logic req);
      instr_done = 1'b1; instr_len = len; cmd_ei = ei; cmd_di = di; irq_req = req;
      step();
      idle_inputs();
   endtask

   task automatic t_reset();
      rst = 1'b1;
      idle_inputs();
      dev_vec = 3'd0;
      step(); step();
      rst = 1'b0;
      chk("R1", "inte", 16'(inte), 16'd0);
      chk("R1", "pc", pc, 16'h0000);
      chk("R1", "inta", 16'(inta), 16'd0);
      chk("R1", "push_valid", 16'(push_valid), 16'd0);
      chk("R1", "core_hold", 16'(core_hold), 16'd0);
   endtask

   task automatic t_advance();
      logic [15:0] p;
      p = pc;
      retire(2'd1, 1'b0, 1'b0, 1'b0);
      chk("R2", "pc +1", pc, p + 16'd1);
      retire(2'd3, 1'b0, 1'b0, 1'b0);
      chk("R2", "pc +3", pc, p + 16'd4);
      step();
      chk("R2", "pc idle", pc, p + 16'd4);
   endtask

   task automatic t_disabled_ignores();
      logic [15:0] p;
      p = pc;
      retire(2'd2, 1'b0, 1'b0, 1'b1);
      chk("R5", "inta", 16'(inta), 16'd0);
      chk("R5", "pc", pc, p + 16'd2);
      chk("R5", "hold", 16'(core_hold), 16'd0);
   endtask

   task automatic t_ei_delay();
      logic [15:0] p;
      retire(2'd1, 1'b1, 1'b0, 1'b1);
      chk("R3", "no accept at EI boundary", 16'(inta), 16'd0);
      chk("R3", "inte still 0", 16'(inte), 16'd0);
      retire(2'd1, 1'b0, 1'b0, 1'b0);
      chk("R3", "inte after next boundary", 16'(inte), 16'd1);
      p = pc;
      retire(2'd1, 1'b0, 1'b1, 1'b1);
      chk("R4", "no accept at DI boundary", 16'(inta), 16'd0);
      chk("R4", "inte cleared", 16'(inte), 16'd0);
      chk("R4", "pc", pc, p + 16'd1);
   endtask

   task automatic enable_ints();
      retire(2'd1, 1'b1, 1'b0, 1'b0);
      retire(2'd1, 1'b0, 1'b0, 1'b0);
      chk("R3", "enabled", 16'(inte), 16'd1);
   endtask

   // accept a request; when noisy, hammer the commands during the hold
   task automatic t_accept(input logic [2:0] n, input logic [1:0] len,
                           input logic noisy);
      logic [15:0] ret;
      ret = pc + 16'(len);
      dev_vec = n;
      retire(len, 1'b0, 1'b0, 1'b1);
      chk("R2", "pc at accept boundary", pc, ret);
      chk("R6", "inta high", 16'(inta), 16'd1);
      chk("R6", "hold", 16'(core_hold), 16'd1);
      chk("R6", "inte cleared", 16'(inte), 16'd0);
      chk("R7", "bus opcode", 16'(data_bus), 16'({2'b11, n, 3'b111}));
      if (noisy) begin
         instr_done = 1'b1; instr_len = 2'd3; cmd_ei = 1'b1;
      end
      step();
      chk("R6", "inta single", 16'(inta), 16'd0);
      chk("R7", "bus idle", 16'(data_bus), 16'h0000);
      chk("R8", "push_valid", 16'(push_valid), 16'd1);
      chk("R8", "push_addr", push_addr, ret);
      chk("R8", "pc not advanced", pc, ret);
      chk("R6", "hold second cycle", 16'(core_hold), 16'd1);
      step();
      idle_inputs();
      chk("R8", "push one cycle", 16'(push_valid), 16'd0);
      chk("R9", "pc target", pc, 16'(n) * 16'd8);
      chk("R9", "hold released", 16'(core_hold), 16'd0);
      if (noisy) begin
         chk("R10", "pc untouched by hold", pc, 16'(n) * 16'd8);
         retire(2'd1, 1'b0, 1'b0, 1'b0);
         chk("R10", "EI during hold ignored", 16'(inte), 16'd0);
      end
   endtask

   task automatic t_ei_then_accept();
      retire(2'd1, 1'b1, 1'b0, 1'b1);
      chk("R3", "held off", 16'(inta), 16'd0);
      dev_vec = 3'd2;
      retire(2'd1, 1'b0, 1'b0, 1'b1);
      chk("R3", "accepted next boundary", 16'(inta), 16'd1);
      step(); step();
      chk("R9", "pc slot 2", pc, 16'h0010);
   endtask

   initial begin
      t_reset();
      t_advance();
      t_disabled_ignores();
      t_ei_delay();
      enable_ints();
      t_accept(3'd0, 2'd1, 1'b0);
      enable_ints();
      t_accept(3'd1, 2'd3, 1'b0);
      enable_ints();
      t_accept(3'd5, 2'd2, 1'b1);
      enable_ints();
      t_accept(3'd7, 2'd0, 1'b0);
      t_ei_then_accept();
      t_disabled_ignores();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=<5000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule